// File: doc/BRIEF.md
# DMA Context-Entry Translation Decision Unit

This block sits behind the context-entry fetch of an I/O address remapping unit. Once the entry for a requesting device is available, the unit looks at four things: the kind of request (untranslated, already translated, or a translation request), the entry's translation-type and address-width fields, the supported-width bitmap from the capability register, and the pass-through capability flag. One cycle later it gives exactly one of three outcomes. The first is a start pulse for a second-level page walk, together with the walk depth. The second is a pass-through grant, which echoes the request address and length. The third is a fault pulse with a code.

The unit also computes, without a register, the deepest paging level the bitmap allows. The pass-through path uses this level. The walk engine and the fault logger can read it as well. This block does not fetch entries, log faults or walk tables.

Top module: `ctx_xlate_decide`

## Requirements
- R1: `max_level` is combinational from `width_map`. It is 5 if bit 3 is set, otherwise 4 if bit 2 is set, otherwise 3 if bit 1 is set, otherwise 0. Bit 0 and any bits above bit 3 are ignored.
- R2: With `xlate_type`=0 and an untranslated request (`req_kind`=0), the unit checks the address width. If `addr_width` is 1, 2 or 3 and `width_map[addr_width]` is set, it pulses `walk_start` with `walk_level` = `addr_width`+2.
- R3: With `xlate_type`=0 and any other `req_kind` (1 translated, 2 translation request, 3 treated the same way), the unit faults with code 1 (bad request kind). The width is not checked in this case.
- R4: With `xlate_type`=0, an untranslated request and a width that fails the R2 test, the unit faults with code 2 (bad width).
- R5: With `xlate_type`=2, `pt_supported`=1, an untranslated request and `addr_width`+2 equal to a non-zero `max_level`, the unit pulses `pass_grant`. In the same cycle `pass_addr` equals the request address and `pass_len` equals the request length.
- R6: With `xlate_type`=2, `pt_supported`=1 and a request that is not untranslated, the unit faults with code 1.
- R7: With `xlate_type`=2, `pt_supported`=1, an untranslated request and `addr_width`+2 not equal to `max_level` (this includes the case `max_level`=0), the unit faults with code 4 (pass-through width).
- R8: `xlate_type` 1, `xlate_type` 3, and `xlate_type` 2 with `pt_supported`=0 all fault with code 3 (reserved type). This holds for every request kind and every width.
- R9: The cycle after a clock edge that samples `req_valid`=1, exactly one of `walk_start`, `pass_grant`, `fault_valid` is high, for one cycle. When `req_valid`=0 is sampled, all three are low. `fault_code` is 0 whenever `fault_valid` is low.
- R10: While `rst_n` is low, `walk_start`, `pass_grant` and `fault_valid` are low and `fault_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request with its fetched context entry is present |
| req_kind | input | 2 | 0 untranslated, 1 translated, 2 translation request, 3 treated as non-untranslated |
| xlate_type | input | 2 | Context-entry translation type |
| addr_width | input | 3 | Context-entry address-width field |
| width_map | input | MAP_W | Capability supported-width bitmap |
| pt_supported | input | 1 | Extended-capability pass-through flag |
| req_addr | input | ADDR_W | Request DMA address |
| req_len | input | LEN_W | Request length |
| max_level | output | 3 | Deepest supported paging level, 0 if none |
| walk_start | output | 1 | Start a second-level walk |
| walk_level | output | 3 | Walk depth, valid with walk_start |
| pass_grant | output | 1 | Request passes through untranslated |
| pass_addr | output | ADDR_W | Output address for pass-through |
| pass_len | output | LEN_W | Contiguous length for pass-through |
| fault_valid | output | 1 | Request faulted |
| fault_code | output | 3 | Fault code (1 kind, 2 width, 3 reserved, 4 pass-through width) |

## Verification
The decision path is swept over every combination of request kind, translation type, the eight width-field values, all sixteen low bitmaps and both pass-through settings. This tells apart the cases where a width-dependent outcome must win from the cases where kind gating or the reserved-type rule must win first. Bitmaps with holes, bitmaps with only bit 0 set, and the empty bitmap separate a plain membership test from the largest-level test that pass-through uses. A different address and length on each request confirm that pass-through echoes the current request and not a stale one. Idle cycles between requests confirm that the outcome lasts one cycle and that nothing fires without a request.

// File: rtl/ctx_xlate_pkg.sv
package ctx_xlate_pkg;
  typedef enum logic [1:0] {
    KIND_UNTRANSLATED = 2'd0,
    KIND_TRANSLATED   = 2'd1,
    KIND_XLATE_REQ    = 2'd2,
    KIND_OTHER        = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    TT_SECOND_LEVEL = 2'd0,
    TT_DEV_TLB      = 2'd1,
    TT_PASS_THRU    = 2'd2,
    TT_RESERVED     = 2'd3
  } xlate_type_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_KIND     = 3'd1,
    FLT_WIDTH    = 3'd2,
    FLT_RESERVED = 3'd3,
    FLT_PT_WIDTH = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_WALK  = 2'd1,
    RT_PASS  = 2'd2,
    RT_FAULT = 2'd3
  } route_e;

  localparam int unsigned LVL_W = 3;
endpackage

// File: rtl/ctx_level_eval.sv
module ctx_level_eval
  import ctx_xlate_pkg::*;
#(
  parameter int unsigned MAP_W = 4
) (
  input  logic [MAP_W-1:0] width_map,
  input  logic [2:0]       addr_width,
  output logic [LVL_W-1:0] max_level,
  output logic [LVL_W-1:0] aw_level,
  output logic             aw_in_map,
  output logic             aw_is_max
);
  localparam int unsigned FIRST_BIT = 1;
  localparam int unsigned LAST_BIT  = 3;

  logic [3:0] lvl_full;

  // Ascending scan: the highest set bit in range wins.
  always_comb begin
    max_level = '0;
    for (int unsigned i = FIRST_BIT; i <= LAST_BIT; i++) begin
      if (i < MAP_W && width_map[i]) max_level = LVL_W'(i + 2);
    end
  end

  always_comb begin
    lvl_full  = {1'b0, addr_width} + 4'd2;
    aw_level  = lvl_full[LVL_W-1:0];
    aw_in_map = (addr_width >= 3'(FIRST_BIT)) && (addr_width <= 3'(LAST_BIT))
                && width_map[addr_width[1:0]];
    aw_is_max = (max_level != '0) && (lvl_full == {1'b0, max_level});
  end
endmodule

// File: rtl/ctx_route_sel.sv
module ctx_route_sel
  import ctx_xlate_pkg::*;
(
  input  logic [1:0] req_kind,
  input  logic [1:0] xlate_type,
  input  logic       pt_supported,
  input  logic       aw_in_map,
  input  logic       aw_is_max,
  output route_e     route,
  output fault_e     code
);
  logic untranslated;

  always_comb begin
    untranslated = (req_kind == KIND_UNTRANSLATED);
    route = RT_FAULT;
    code  = FLT_RESERVED;
    unique case (xlate_type)
      TT_SECOND_LEVEL: begin
        if (!untranslated)  begin route = RT_FAULT; code = FLT_KIND;  end
        else if (aw_in_map) begin route = RT_WALK;  code = FLT_NONE;  end
        else                begin route = RT_FAULT; code = FLT_WIDTH; end
      end
      TT_PASS_THRU: begin
        if (!pt_supported)  begin route = RT_FAULT; code = FLT_RESERVED; end
        else if (!untranslated) begin route = RT_FAULT; code = FLT_KIND; end
        else if (aw_is_max) begin route = RT_PASS;  code = FLT_NONE; end
        else                begin route = RT_FAULT; code = FLT_PT_WIDTH; end
      end
      default: begin route = RT_FAULT; code = FLT_RESERVED; end
    endcase
  end
endmodule

// File: rtl/ctx_xlate_decide.sv
module ctx_xlate_decide
  import ctx_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned MAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        xlate_type,
  input  logic [2:0]        addr_width,
  input  logic [MAP_W-1:0]  width_map,
  input  logic              pt_supported,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [2:0]        max_level,
  output logic              walk_start,
  output logic [2:0]        walk_level,
  output logic              pass_grant,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [LEN_W-1:0]  pass_len,
  output logic              fault_valid,
  output logic [2:0]        fault_code
);
  logic [LVL_W-1:0] aw_level;
  logic             aw_in_map, aw_is_max;
  route_e           route;
  fault_e           code;

  ctx_level_eval #(.MAP_W(MAP_W)) u_level (
    .width_map (width_map),
    .addr_width(addr_width),
    .max_level (max_level),
    .aw_level  (aw_level),
    .aw_in_map (aw_in_map),
    .aw_is_max (aw_is_max)
  );

  ctx_route_sel u_route (
    .req_kind    (req_kind),
    .xlate_type  (xlate_type),
    .pt_supported(pt_supported),
    .aw_in_map   (aw_in_map),
    .aw_is_max   (aw_is_max),
    .route       (route),
    .code        (code)
  );

  // Next-state
  logic              walk_d, pass_d, fault_d, pass_en, walk_en;
  logic [2:0]        code_d;

  always_comb begin
    walk_d  = req_valid && (route == RT_WALK);
    pass_d  = req_valid && (route == RT_PASS);
    fault_d = req_valid && (route == RT_FAULT);
    code_d  = fault_d ? code : FLT_NONE;
    pass_en = pass_d;
    walk_en = walk_d;
  end

  // Registers: pulses and fault code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_start  <= 1'b0;
      pass_grant  <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
    end else begin
      walk_start  <= walk_d;
      pass_grant  <= pass_d;
      fault_valid <= fault_d;
      fault_code  <= code_d;
    end
  end

  // Registers: payloads, loaded only with their own outcome
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_level <= '0;
      pass_addr  <= '0;
      pass_len   <= '0;
    end else begin
      if (walk_en) walk_level <= aw_level;
      if (pass_en) begin
        pass_addr <= req_addr;
        pass_len  <= req_len;
      end
    end
  end

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) |-> $countones({walk_start, pass_grant, fault_valid}) == 1);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !(walk_start || pass_grant || fault_valid));
  // R9
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> fault_code == 3'd0);
  // R2
  walk_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> (walk_level >= 3'd3 && walk_level <= 3'd5));
  // R5
  pass_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_grant |-> (pass_addr == $past(req_addr) && pass_len == $past(req_len)));
  // R8
  reserved_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $past(xlate_type) == 2'd1) |-> (fault_valid && fault_code == 3'd3));
  // R1
  max_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_level == 3'd0 || (max_level >= 3'd3 && max_level <= 3'd5));
endmodule

// File: tb/sim_ctx_xlate_decide.sv
module sim_ctx_xlate_decide;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned MAP_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_kind = '0;
  logic [1:0]        xlate_type = '0;
  logic [2:0]        addr_width = '0;
  logic [MAP_W-1:0]  width_map = '0;
  logic              pt_supported = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [2:0]        max_level, walk_level, fault_code;
  logic              walk_start, pass_grant, fault_valid;
  logic [ADDR_W-1:0] pass_addr;
  logic [LEN_W-1:0]  pass_len;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctx_xlate_decide #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAP_W(MAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .xlate_type(xlate_type), .addr_width(addr_width), .width_map(width_map),
    .pt_supported(pt_supported), .req_addr(req_addr), .req_len(req_len),
    .max_level(max_level), .walk_start(walk_start), .walk_level(walk_level),
    .pass_grant(pass_grant), .pass_addr(pass_addr), .pass_len(pass_len),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_max(input logic [MAP_W-1:0] m);
    if (m[3]) return 5;
    if (m[2]) return 4;
    if (m[1]) return 3;
    return 0;
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_out; // 0 none,1 walk,2 pass,3 fault
    int exp_code, exp_lvl, got_out;
    string tag;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!walk_start && !pass_grant && !fault_valid && fault_code == 0, "R10",
          {walk_start, pass_grant, fault_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 idle: no outcome without request
    check(!walk_start && !pass_grant && !fault_valid, "R9 idle",
          {walk_start, pass_grant, fault_valid}, 0);

    for (int m = 0; m < 16; m++) begin
      width_map = 4'(m);
      #1;
      // R1
      check(int'(max_level) == exp_max(4'(m)), "R1", max_level, exp_max(4'(m)));
      for (int pt = 0; pt < 2; pt++)
      for (int tt = 0; tt < 4; tt++)
      for (int k = 0; k < 4; k++)
      for (int aw = 0; aw < 8; aw++) begin
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); xlate_type = 2'(tt);
        addr_width = 3'(aw); pt_supported = pt[0];
        req_addr = 16'(m * 4099 + tt * 257 + k * 31 + aw * 7 + pt);
        req_len  = 8'(m * 13 + aw * 3 + k + tt * 5 + pt);
        // expected from requirements
        exp_lvl = aw + 2; exp_code = 0;
        if (tt == 0) begin
          if (k != 0) begin exp_out = 3; exp_code = 1; tag = "R3"; end
          else if (aw >= 1 && aw <= 3 && m[aw]) begin exp_out = 1; tag = "R2"; end
          else begin exp_out = 3; exp_code = 2; tag = "R4"; end
        end else if (tt == 2 && pt == 1) begin
          if (k != 0) begin exp_out = 3; exp_code = 1; tag = "R6"; end
          else if (exp_max(4'(m)) != 0 && exp_lvl == exp_max(4'(m))) begin exp_out = 2; tag = "R5"; end
          else begin exp_out = 3; exp_code = 4; tag = "R7"; end
        end else begin exp_out = 3; exp_code = 3; tag = "R8"; end
        @(negedge clk);
        req_valid = 1'b0;
        got_out = walk_start ? 1 : pass_grant ? 2 : fault_valid ? 3 : 0;
        // R9 exactly one outcome
        check(int'(walk_start) + int'(pass_grant) + int'(fault_valid) == 1, "R9 one-hot",
              int'(walk_start) + int'(pass_grant) + int'(fault_valid), 1);
        check(got_out == exp_out, tag, got_out, exp_out);
        if (exp_out == 3) check(int'(fault_code) == exp_code, tag, fault_code, exp_code);
        else check(fault_code == 0, "R9 code idle", fault_code, 0);
        if (exp_out == 1) check(int'(walk_level) == exp_lvl, "R2 level", walk_level, exp_lvl);
        if (exp_out == 2) begin
          check(pass_addr == req_addr, "R5 addr", pass_addr, req_addr);
          check(pass_len == req_len, "R5 len", pass_len, req_len);
        end
        @(negedge clk);
        // R9 single-cycle pulse
        check(!walk_start && !pass_grant && !fault_valid, "R9 pulse",
              {walk_start, pass_grant, fault_valid}, 0);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule